// File: doc/BRIEF.md
# Color-Routed Five-Port Mesh Router Tile

This block is one router tile of a two-dimensional mesh fabric. It has five bidirectional ports. Port 0 faces north, port 1 south, port 2 east and port 3 west. Port 4 connects to the local compute core. Each small message, called a wavelet, carries a 32-bit payload and a 5-bit color tag. A static routing table decides where the wavelet goes. The table holds one 5-bit output mask for each pair of input port and color. The tile sends the wavelet to every port whose bit is set in that mask, so a single wavelet can go to one port or be copied to several.

Each input port holds one wavelet in a small state machine with two states. `P_IDLE` means the slot is empty. `P_SEND` means a wavelet is held and at least one output in its mask has not yet taken it. The transitions are:
- *take*: P_IDLE to P_SEND, when a wavelet with a non-zero mask is accepted.
- *drop*: P_IDLE to P_IDLE, when the wavelet accepted has a zero mask or an invalid color.
- *drain-partial*: P_SEND to P_SEND, when some of the outputs still owed a copy take it.
- *finish*: P_SEND to P_IDLE, when the last owed outputs take it.
- *finish-and-take*: P_SEND to P_SEND, when the last copies leave in the same cycle that a new wavelet is accepted.

Each output has a round-robin arbiter that picks one of the competing inputs. Software loads the table through a write port before traffic starts.

Top module: `mesh_color_router`

## Requirements
- R1: After reset every `out_valid` bit is 0, every `in_ready` bit is 1, and every table mask is zero, so a wavelet sent before any table write appears on no output.
- R2: A wavelet accepted at one rising edge is presented on its routed output during the very next cycle, with the payload and the color unchanged. Port p uses data bits [32p+31:32p] and color bits [5p+4:5p].
- R3: Bit k of a table mask sends a copy to output port k. Every output whose bit is set presents the same payload in the same cycle.
- R4: An input keeps its wavelet, and holds `in_ready` low, until every output in its mask has completed a valid/ready transfer. Outputs that have already taken their copy do not present it again.
- R5: A wavelet whose mask is zero is accepted and discarded. No output becomes valid and the input stays ready.
- R6: Colors 0 to 23 are valid. A wavelet with a color from 24 to 31 is discarded no matter what the table holds, and table writes that name such a color are ignored.
- R7: When several inputs compete for one output, that output grants them in round-robin order. The search starts at the port after the last winner, and after reset it starts at port 0. Losing inputs keep their wavelet without loss.
- R8: Table entries are separate for each input port. The same color arriving on two different ports follows each port's own mask.
- R9: An output whose `out_ready` is low keeps `out_valid` high in the following cycle.
- R10: A stream of wavelets on one input toward a free output moves one wavelet per cycle, with `in_ready` staying high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 5 | Wavelet offered on each input port |
| in_ready | output | 5 | Input port can take a wavelet |
| in_data | input | 160 | Payloads, 32 bits per port |
| in_color | input | 25 | Colors, 5 bits per port |
| out_valid | output | 5 | Wavelet presented on each output port |
| out_ready | input | 5 | Neighbour takes the presented wavelet |
| out_data | output | 160 | Output payloads, 32 bits per port |
| out_color | output | 25 | Output colors, 5 bits per port |
| cfg_we | input | 1 | Table write strobe |
| cfg_port | input | 3 | Input port of the entry being written |
| cfg_color | input | 5 | Color of the entry being written |
| cfg_mask | input | 5 | Output mask to store |

## Verification
The bench tries the routing function with five kinds of input pattern:
- A single unicast wavelet pins down the one-cycle hop and shows that payload and color pass through unchanged.
- A three-way multicast, first with only part of the outputs ready and then with all of them, separates "leaves once every copy is taken" from "leaves after the first copy".
- The same color sent on two ports at once shows that the table is indexed by port.
- Three inputs and then two inputs contending for one output tell a rotating arbiter apart from a fixed-priority one.
- A back-to-back stream, a zero mask and an out-of-range color cover throughput and the two ways a wavelet is dropped.

// File: rtl/router_pkg.sv
package router_pkg;
    localparam int NPORT = 5;
    localparam int IDX_W = $clog2(NPORT);

    localparam int PORT_N = 0;
    localparam int PORT_S = 1;
    localparam int PORT_E = 2;
    localparam int PORT_W = 3;
    localparam int PORT_L = 4;

    typedef enum logic {
        P_IDLE = 1'b0,
        P_SEND = 1'b1
    } slot_state_e;
endpackage

// File: rtl/color_route_table.sv
module color_route_table
    import router_pkg::*;
#(
    parameter int COLOR_W    = 5,
    parameter int NUM_COLORS = 24
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               wr_en,
    input  logic [2:0]                         wr_port,
    input  logic [COLOR_W-1:0]                 wr_color,
    input  logic [NPORT-1:0]                   wr_mask,
    input  logic [NPORT-1:0][COLOR_W-1:0]      look_color,
    output logic [NPORT-1:0][NPORT-1:0]        look_mask
);
    logic [NPORT-1:0] masks [NPORT][NUM_COLORS];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int p = 0; p < NPORT; p++)
                for (int c = 0; c < NUM_COLORS; c++)
                    masks[p][c] <= '0;
        end else if (wr_en && (int'(wr_port) < NPORT) && (int'(wr_color) < NUM_COLORS)) begin
            masks[wr_port][wr_color] <= wr_mask;
        end
    end

    // Out-of-range colors map to an empty mask (R6).
    always_comb begin
        for (int p = 0; p < NPORT; p++) begin
            if (int'(look_color[p]) < NUM_COLORS)
                look_mask[p] = masks[p][look_color[p]];
            else
                look_mask[p] = '0;
        end
    end
endmodule

// File: rtl/input_slot.sv
module input_slot
    import router_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int COLOR_W = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [DATA_W-1:0]  in_data,
    input  logic [COLOR_W-1:0] in_color,
    input  logic [NPORT-1:0]   route_mask,
    input  logic [NPORT-1:0]   served,
    output logic [NPORT-1:0]   pending,
    output logic [DATA_W-1:0]  held_data,
    output logic [COLOR_W-1:0] held_color
);
    slot_state_e state, state_nx;
    logic [NPORT-1:0] pend_nx;
    logic [NPORT-1:0] left;
    logic             take;
    logic             done;

    assign left     = pending & ~served;
    assign done     = (state == P_SEND) && (left == '0);
    assign in_ready = (state == P_IDLE) || done;
    assign take     = in_valid && in_ready;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= P_IDLE;
            pending <= '0;
        end else begin
            state   <= state_nx;
            pending <= pend_nx;
        end
    end

    always_ff @(posedge clk) begin
        if (take) begin
            held_data  <= in_data;
            held_color <= in_color;
        end
    end

    always_comb begin
        state_nx = state;
        pend_nx  = pending;
        unique case (state)
            P_IDLE: begin
                if (take && route_mask != '0) begin
                    state_nx = P_SEND;
                    pend_nx  = route_mask;
                end else begin
                    pend_nx  = '0;
                end
            end
            P_SEND: begin
                if (!done) begin
                    pend_nx = left;
                end else if (take && route_mask != '0) begin
                    pend_nx = route_mask;
                end else begin
                    state_nx = P_IDLE;
                    pend_nx  = '0;
                end
            end
            default: begin
                state_nx = P_IDLE;
                pend_nx  = '0;
            end
        endcase
    end

    // R5
    drop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && route_mask == '0) |=> (state == P_IDLE && pending == '0));

    // R4
    hold_until_served_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == P_SEND && left != '0) |=> (state == P_SEND && $stable(held_data)));
endmodule

// File: rtl/rr_output_arb.sv
module rr_output_arb
    import router_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPORT-1:0] req,
    input  logic             ready,
    output logic             valid,
    output logic [NPORT-1:0] grant
);
    logic [IDX_W-1:0] last_win;
    logic [IDX_W-1:0] win;
    logic             found;
    int               idx;

    assign valid = |req;

    always_comb begin
        grant = '0;
        win   = last_win;
        found = 1'b0;
        idx   = 0;
        for (int k = 1; k <= NPORT; k++) begin
            idx = (int'(last_win) + k) % NPORT;
            if (!found && req[idx]) begin
                found      = 1'b1;
                grant[idx] = 1'b1;
                win        = IDX_W'(idx);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            last_win <= IDX_W'(NPORT - 1);
        else if (valid && ready)
            last_win <= win;
    end

    // R7
    grant_in_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((grant & ~req) == '0) && (valid == (grant != '0)));

    // R9
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !ready) |=> valid);
endmodule

// File: rtl/mesh_color_router.sv
module mesh_color_router
    import router_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int COLOR_W    = 5,
    parameter int NUM_COLORS = 24
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NPORT-1:0]           in_valid,
    output logic [NPORT-1:0]           in_ready,
    input  logic [NPORT*DATA_W-1:0]    in_data,
    input  logic [NPORT*COLOR_W-1:0]   in_color,
    output logic [NPORT-1:0]           out_valid,
    input  logic [NPORT-1:0]           out_ready,
    output logic [NPORT*DATA_W-1:0]    out_data,
    output logic [NPORT*COLOR_W-1:0]   out_color,
    input  logic                       cfg_we,
    input  logic [2:0]                 cfg_port,
    input  logic [COLOR_W-1:0]         cfg_color,
    input  logic [NPORT-1:0]           cfg_mask
);
    logic [NPORT-1:0][COLOR_W-1:0] look_color;
    logic [NPORT-1:0][NPORT-1:0]   look_mask;
    logic [NPORT-1:0]              pend   [NPORT];
    logic [NPORT-1:0]              req    [NPORT];
    logic [NPORT-1:0]              gnt    [NPORT];
    logic [NPORT-1:0]              served [NPORT];
    logic [DATA_W-1:0]             hdata  [NPORT];
    logic [COLOR_W-1:0]            hcolor [NPORT];

    always_comb begin
        for (int p = 0; p < NPORT; p++)
            look_color[p] = in_color[p*COLOR_W +: COLOR_W];
    end

    color_route_table #(.COLOR_W(COLOR_W), .NUM_COLORS(NUM_COLORS)) u_table (
        .clk(clk), .rst_n(rst_n),
        .wr_en(cfg_we), .wr_port(cfg_port), .wr_color(cfg_color), .wr_mask(cfg_mask),
        .look_color(look_color), .look_mask(look_mask)
    );

    // Transpose: input i's pending bits become requests at each output.
    always_comb begin
        for (int o = 0; o < NPORT; o++)
            for (int i = 0; i < NPORT; i++) begin
                req[o][i]    = pend[i][o];
                served[i][o] = gnt[o][i] & out_ready[o];
            end
    end

    generate
        for (genvar p = 0; p < NPORT; p++) begin : g_port
            input_slot #(.DATA_W(DATA_W), .COLOR_W(COLOR_W)) u_slot (
                .clk(clk), .rst_n(rst_n),
                .in_valid(in_valid[p]), .in_ready(in_ready[p]),
                .in_data(in_data[p*DATA_W +: DATA_W]),
                .in_color(in_color[p*COLOR_W +: COLOR_W]),
                .route_mask(look_mask[p]), .served(served[p]),
                .pending(pend[p]), .held_data(hdata[p]), .held_color(hcolor[p])
            );

            rr_output_arb u_arb (
                .clk(clk), .rst_n(rst_n),
                .req(req[p]), .ready(out_ready[p]),
                .valid(out_valid[p]), .grant(gnt[p])
            );
        end
    endgenerate

    always_comb begin
        out_data  = '0;
        out_color = '0;
        for (int o = 0; o < NPORT; o++)
            for (int i = 0; i < NPORT; i++)
                if (gnt[o][i]) begin
                    out_data[o*DATA_W +: DATA_W]    = hdata[i];
                    out_color[o*COLOR_W +: COLOR_W] = hcolor[i];
                end
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (out_valid == '0 && in_ready == '1));
endmodule

// File: tb/sim_mesh_color_router.sv
module sim_mesh_color_router;
    localparam int NP = 5;
    localparam int DW = 32;
    localparam int CW = 5;

    logic              clk = 1'b0;
    logic              rst_n;
    logic [NP-1:0]     in_valid, in_ready, out_valid, out_ready;
    logic [NP*DW-1:0]  in_data, out_data;
    logic [NP*CW-1:0]  in_color, out_color;
    logic              cfg_we;
    logic [2:0]        cfg_port;
    logic [CW-1:0]     cfg_color;
    logic [NP-1:0]     cfg_mask;

    int  n_run  = 0;
    int  n_fail = 0;
    bit  finished = 1'b0;

    always #5 clk = ~clk;

    mesh_color_router u0 (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_color(in_color),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_color(out_color),
        .cfg_we(cfg_we), .cfg_port(cfg_port), .cfg_color(cfg_color), .cfg_mask(cfg_mask)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] od(input int p);
        return out_data[p*DW +: DW];
    endfunction

    task automatic route(input int p, input int c, input logic [NP-1:0] m);
        @(negedge clk);
        cfg_we = 1'b1; cfg_port = 3'(p); cfg_color = CW'(c); cfg_mask = m;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic offer(input int p, input int c, input logic [DW-1:0] d);
        in_valid[p] = 1'b1;
        in_color[p*CW +: CW] = CW'(c);
        in_data[p*DW +: DW]  = d;
    endtask

    task automatic t_reset;
        chk("R1 out_valid after reset", 64'(out_valid), 64'h0);
        chk("R1 in_ready after reset", 64'(in_ready), 64'h1f);
        @(negedge clk); offer(0, 0, 32'h1111_0000);
        @(negedge clk); in_valid = '0;
        chk("R1 empty table sends nothing", 64'(out_valid), 64'h0);
    endtask

    task automatic t_unicast;
        route(0, 1, 5'b00100);
        offer(0, 1, 32'hA5A5_0001);
        @(negedge clk); in_valid = '0;
        chk("R2 unicast valid next cycle", 64'(out_valid), 64'h04);
        chk("R2 unicast data", 64'(od(2)), 64'hA5A5_0001);
        chk("R2 unicast color", 64'(out_color[2*CW +: CW]), 64'd1);
        @(negedge clk);
        chk("R2 single transfer only", 64'(out_valid), 64'h0);
    endtask

    task automatic t_multicast;
        route(0, 5, 5'b10110);
        out_ready = 5'b00010;
        offer(0, 5, 32'hC0DE_0005);
        @(negedge clk); in_valid = '0;
        chk("R3 multicast fan-out", 64'(out_valid), 64'h16);
        chk("R3 copy south", 64'(od(1)), 64'hC0DE_0005);
        chk("R3 copy east", 64'(od(2)), 64'hC0DE_0005);
        chk("R3 copy local", 64'(od(4)), 64'hC0DE_0005);
        chk("R4 input held while copies owed", 64'(in_ready[0]), 64'h0);
        @(negedge clk);
        chk("R4 served output not repeated", 64'(out_valid), 64'h14);
        chk("R9 stalled outputs keep valid", 64'(od(4)), 64'hC0DE_0005);
        chk("R4 still held", 64'(in_ready[0]), 64'h0);
        out_ready = '1;
        @(negedge clk);
        chk("R4 released after all copies", 64'(in_ready[0]), 64'h1);
        chk("R4 nothing left", 64'(out_valid), 64'h0);
    endtask

    task automatic t_drops;
        route(2, 7, 5'b00000);
        route(1, 9, 5'b00001);
        offer(2, 7, 32'hDEAD_0007);
        offer(1, 25, 32'hDEAD_0019);
        @(negedge clk); in_valid = '0;
        chk("R5/R6 dropped wavelets not sent", 64'(out_valid), 64'h0);
        chk("R5 zero-mask input stays ready", 64'(in_ready[2]), 64'h1);
        chk("R6 bad-color input stays ready", 64'(in_ready[1]), 64'h1);
        route(1, 25, 5'b00001);
        offer(1, 25, 32'hDEAD_0119);
        @(negedge clk); in_valid = '0;
        chk("R6 write to color 25 ignored", 64'(out_valid), 64'h0);
    endtask

    task automatic t_per_port;
        route(3, 10, 5'b00001);
        route(4, 10, 5'b00010);
        offer(3, 10, 32'h3333_000A);
        offer(4, 10, 32'h4444_000A);
        @(negedge clk); in_valid = '0;
        chk("R8 per-port masks", 64'(out_valid), 64'h03);
        chk("R8 west input to north", 64'(od(0)), 64'h3333_000A);
        chk("R8 local input to south", 64'(od(1)), 64'h4444_000A);
        @(negedge clk);
    endtask

    task automatic t_round_robin;
        for (int p = 0; p < 4; p++) route(p, 12, 5'b01000);
        offer(0, 12, 32'h0000_00D0);
        offer(1, 12, 32'h0000_00D1);
        offer(2, 12, 32'h0000_00D2);
        @(negedge clk); in_valid = '0;
        chk("R7 first grant port 0", 64'(od(3)), 64'hD0);
        @(negedge clk);
        chk("R7 second grant port 1", 64'(od(3)), 64'hD1);
        @(negedge clk);
        chk("R7 third grant port 2", 64'(od(3)), 64'hD2);
        offer(0, 12, 32'h0000_00E0);
        offer(3, 12, 32'h0000_00E3);
        @(negedge clk); in_valid = '0;
        chk("R7 rotation favours port 3", 64'(od(3)), 64'hE3);
        @(negedge clk);
        chk("R7 loser kept its wavelet", 64'(od(3)), 64'hE0);
        @(negedge clk);
        chk("R7 contention drained", 64'(out_valid), 64'h0);
    endtask

    task automatic t_stream;
        route(4, 3, 5'b00100);
        offer(4, 3, 32'h5000_0000);
        for (int k = 1; k <= 4; k++) begin
            @(negedge clk);
            chk("R10 stream word on east", 64'(od(2)), 64'(32'h5000_0000 + k - 1));
            chk("R10 input ready every cycle", 64'(in_ready[4]), 64'h1);
            if (k < 4) offer(4, 3, 32'h5000_0000 + k);
            else in_valid = '0;
        end
        @(negedge clk);
        chk("R10 stream ends", 64'(out_valid), 64'h0);
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; in_valid = '0; in_data = '0; in_color = '0;
        out_ready = '1; cfg_we = 1'b0; cfg_port = '0; cfg_color = '0; cfg_mask = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_unicast();
        t_multicast();
        t_drops();
        t_per_port();
        t_round_robin();
        t_stream();
        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule